// File: doc/BRIEF.md
# Bulk Erase Verify Sequencer

This block is a host-side controller that erases a whole byte-wide parallel flash array and then confirms the erase one byte at a time. After a start strobe, it waits until a separate programming sequencer reports that every byte already holds zero. It then issues the two-write erase command and lets the erase pulse run for a set number of clocks. After that it walks the address space. For each byte it writes a verify command carrying that byte's address, waits a short settling time, reads the byte back and compares it with all ones.

When a byte reads back anything but all ones, the sequencer issues another erase pulse and continues from the byte that failed rather than from address zero. The number of erase pulses has an upper bound. When that bound is reached without a clean pass, the run ends with an error. Every run, clean or failed, ends by writing the read-mode command, and then `done_o` rises.

The flash is reached through a simple synchronous bus master port. The request and its attributes are held until an acknowledge arrives, and read data is taken in the acknowledge cycle. The array depth, the two wait lengths and the pulse limit are parameters.

Top module: `flash_bulk_erase`

## Requirements
- R1: After reset the block makes no bus request and holds `done_o` and `err_o` low.
- R2: After `start_i`, no bus cycle is issued while `array_ready_i` is low.
- R3: An erase pulse is two back-to-back writes of data 20h. It is followed by at least `ERASE_CYC` clocks with no bus activity before the next cycle.
- R4: Each byte check is a write of data A0h to the byte's address, then at least `VERIFY_CYC` quiet clocks, then a read (`bus_we_o`=0) of the same address. A request holds its address, data and direction until acknowledged.
- R5: A read value of FFh advances to the next address. When address `DEPTH-1` passes, the block writes 00h, then sets `done_o`=1 with `err_o`=0.
- R6: A read value other than FFh causes a new erase pulse. Verification then resumes at the failing address, not at address zero.
- R7: When the `MAX_PULSES`-th erase pulse still leaves a byte reading not FFh, no further pulse is issued. The block writes 00h and sets `done_o`=1 and `err_o`=1.
- R8: If the last byte first verifies after exactly `MAX_PULSES` pulses, the run ends with `err_o`=0.
- R9: A new `start_i` after a finished run clears `done_o` and `err_o` and restarts with address and pulse count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken while idle |
| array_ready_i | input | 1 | Array has been pre-programmed to zero |
| bus_req_o | output | 1 | Bus request, held until acknowledged |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | $clog2(DEPTH) | Byte address |
| bus_wdata_o | output | 8 | Write data (command byte) |
| bus_ack_i | input | 1 | Transfer acknowledge |
| bus_rdata_i | input | 8 | Read data, valid with acknowledge |
| done_o | output | 1 | Run finished, held until the next start |
| err_o | output | 1 | Run ended on the pulse limit |

## Verification
The pulse-limit check and the end-of-array check can both be decided on the same read: the last byte fails, or passes, exactly on the final permitted pulse. A bus model is used in which only the top byte needs a chosen number of pulses. With that count equal to the limit, the run must finish clean after the full number of pulses. With the count one above the limit, the run must stop at the limit with the error flag set. In both cases the log of verify addresses must show resumption at the top byte, with no restart from zero.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_VERIFY = 8'hA0;
  localparam logic [7:0] CMD_READ   = 8'h00;
  localparam logic [7:0] ERASED     = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WRDY, ST_SETUP, ST_GO, ST_EWAIT,
    ST_VCMD, ST_VWAIT, ST_VRD, ST_RESTORE
  } fe_state_e;
endpackage

// File: rtl/fe_timer.sv
module fe_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  p_load_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (val_i != '0) |=> !expired_o);
endmodule

// File: rtl/fe_counter.sv
module fe_counter #(
  parameter int LIMIT = 8,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST);

  p_cnt_in_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_cnt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/flash_bulk_erase.sv
module flash_bulk_erase
  import flash_erase_pkg::*;
#(
  parameter int DEPTH      = 131072,
  parameter int ERASE_CYC  = 500000,
  parameter int VERIFY_CYC = 300,
  parameter int MAX_PULSES = 1000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     array_ready_i,
  output logic                     bus_req_o,
  output logic                     bus_we_o,
  output logic [$clog2(DEPTH)-1:0] bus_addr_o,
  output logic [7:0]               bus_wdata_o,
  input  logic                     bus_ack_i,
  input  logic [7:0]               bus_rdata_i,
  output logic                     done_o,
  output logic                     err_o
);
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = $clog2(MAX_PULSES + 1);
  localparam int WMAX  = (ERASE_CYC > VERIFY_CYC) ? ERASE_CYC : VERIFY_CYC;
  localparam int TW    = $clog2(WMAX + 1);

  fe_state_e     state_q, state_d;
  logic          done_q, err_q, fail_q, fail_d;
  logic [AW-1:0] addr_q;
  logic [PW-1:0] pulse_q;
  logic          addr_last, pulse_last;
  logic          run_clr, addr_inc, pulse_inc;
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic          match;

  assign match = (bus_rdata_i == ERASED);

  always_comb begin
    state_d   = state_q;
    fail_d    = fail_q;
    run_clr   = 1'b0;
    addr_inc  = 1'b0;
    pulse_inc = 1'b0;
    unique case (state_q)
      ST_IDLE:    if (start_i) begin state_d = ST_WRDY; run_clr = 1'b1; fail_d = 1'b0; end
      ST_WRDY:    if (array_ready_i) state_d = ST_SETUP;
      ST_SETUP:   if (bus_ack_i) state_d = ST_GO;
      ST_GO:      if (bus_ack_i) state_d = ST_EWAIT;
      ST_EWAIT:   if (tmr_done) state_d = ST_VCMD;
      ST_VCMD:    if (bus_ack_i) state_d = ST_VWAIT;
      ST_VWAIT:   if (tmr_done) state_d = ST_VRD;
      ST_VRD: if (bus_ack_i) begin
        if (match) begin
          if (addr_last) state_d = ST_RESTORE;
          else begin addr_inc = 1'b1; state_d = ST_VCMD; end
        end else if (pulse_last) begin
          fail_d  = 1'b1;
          state_d = ST_RESTORE;
        end else begin
          pulse_inc = 1'b1;   // address kept: resume at the failing byte
          state_d   = ST_SETUP;
        end
      end
      ST_RESTORE: if (bus_ack_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fail_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fail_q  <= fail_d;
      if (run_clr) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end else if (state_q == ST_RESTORE && bus_ack_i) begin
        done_q <= 1'b1;
        err_q  <= fail_q;
      end
    end
  end

  fe_counter #(.LIMIT(DEPTH), .W(AW)) i_addr_ctr (
    .clk_i, .rst_ni, .clr_i(run_clr), .inc_i(addr_inc),
    .cnt_o(addr_q), .last_o(addr_last)
  );

  fe_counter #(.LIMIT(MAX_PULSES), .W(PW)) i_pulse_ctr (
    .clk_i, .rst_ni, .clr_i(run_clr), .inc_i(pulse_inc),
    .cnt_o(pulse_q), .last_o(pulse_last)
  );

  assign tmr_load = bus_ack_i && (state_q == ST_GO || state_q == ST_VCMD);
  assign tmr_val  = (state_q == ST_GO) ? TW'(ERASE_CYC) : TW'(VERIFY_CYC);

  fe_timer #(.W(TW)) i_wait (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .expired_o(tmr_done)
  );

  always_comb begin
    bus_req_o   = 1'b0;
    bus_we_o    = 1'b1;
    bus_addr_o  = '0;
    bus_wdata_o = CMD_READ;
    unique case (state_q)
      ST_SETUP, ST_GO: begin bus_req_o = 1'b1; bus_wdata_o = CMD_ERASE; end
      ST_VCMD: begin bus_req_o = 1'b1; bus_wdata_o = CMD_VERIFY; bus_addr_o = addr_q; end
      ST_VRD:  begin bus_req_o = 1'b1; bus_we_o = 1'b0; bus_addr_o = addr_q; end
      ST_RESTORE: bus_req_o = 1'b1;
      default: ;
    endcase
  end

  assign done_o = done_q;
  assign err_o  = err_q;

  p_req_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o)
                               && $stable(bus_wdata_o) && $stable(bus_we_o));
  p_ready_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) && $past(state_q) == ST_WRDY |-> $past(array_ready_i));
  p_resume_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_VRD && bus_ack_i && !match |=> $stable(addr_q));
  p_done_restore_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(state_q == ST_RESTORE && bus_ack_i));
  p_err_limit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> pulse_last);
endmodule

// File: tb/test_flash_bulk_erase.sv
module test_flash_bulk_erase;
  localparam int DEPTH = 8, ECYC = 20, VCYC = 4, MAXP = 4;

  logic clk = 0, rst_n = 0, start = 0, ready = 0;
  logic req, we, ack = 0, done, err;
  logic [2:0] addr;
  logic [7:0] wdata, rdata = 0;

  always #10 clk = ~clk;

  flash_bulk_erase #(.DEPTH(DEPTH), .ERASE_CYC(ECYC), .VERIFY_CYC(VCYC), .MAX_PULSES(MAXP))
  i_flash_bulk_erase (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .array_ready_i(ready),
    .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
    .bus_ack_i(ack), .bus_rdata_i(rdata), .done_o(done), .err_o(err)
  );

  int checks = 0, errors = 0, cyc = 0;
  int need [DEPTH];
  int erases, prev20, after_erase, last_cyc, vaddr, vcnt, rd_bad, unready, min_eg, min_vg;
  int vlog [32];
  logic [7:0] last_wd;

  // flash model: one-cycle acknowledge
  always @(posedge clk) begin
    cyc++;
    if (ack) ack <= 0;
    else if (req) begin
      ack <= 1;
      if (!ready) unready++;
      if (we) begin
        last_wd = wdata;
        if (wdata == 8'h20) begin
          if (prev20 != 0) begin erases++; prev20 = 0; after_erase = 1; end
          else prev20 = 1;
        end else begin
          prev20 = 0;
          if (wdata == 8'hA0) begin
            if (after_erase != 0 && cyc - last_cyc < min_eg) min_eg = cyc - last_cyc;
            after_erase = 0;
            vaddr = int'(addr);
            if (vcnt < 32) vlog[vcnt] = int'(addr);
            vcnt++;
          end
        end
      end else begin
        if (cyc - last_cyc < min_vg) min_vg = cyc - last_cyc;
        if (int'(addr) != vaddr) rd_bad++;
        rdata <= (erases >= need[addr]) ? 8'hFF : 8'h00;
      end
      last_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", r, act, exp); end
  endtask

  task automatic clr_model();
    erases = 0; prev20 = 0; after_erase = 0; vaddr = -1; vcnt = 0;
    rd_bad = 0; unready = 0; min_eg = 1000000; min_vg = 1000000; last_wd = 8'h55;
    for (int i = 0; i < DEPTH; i++) need[i] = 1;
  endtask

  task automatic kick();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!req && !done && !err, "R1", {req, done, err}, 0);
  endtask

  task automatic t_clean();
    clr_model(); ready = 0;
    kick();
    repeat (30) @(negedge clk);
    chk(!req && vcnt == 0, "R2", int'(req), 0);
    ready = 1;
    wait_done();
    chk(unready == 0, "R2", unready, 0);
    chk(erases == 1, "R3", erases, 1);
    chk(min_eg >= ECYC, "R3", min_eg, ECYC);
    chk(vcnt == DEPTH, "R4", vcnt, DEPTH);
    for (int i = 0; i < DEPTH; i++) chk(vlog[i] == i, "R4", vlog[i], i);
    chk(min_vg >= VCYC && rd_bad == 0, "R4", min_vg, VCYC);
    chk(last_wd == 8'h00, "R5", last_wd, 0);
    chk(done && !err, "R5", {done, err}, 2);
  endtask

  task automatic t_resume();
    clr_model(); need[5] = 2;
    kick(); wait_done();
    chk(erases == 2, "R6", erases, 2);
    chk(vcnt == DEPTH + 1, "R6", vcnt, DEPTH + 1);
    chk(vlog[5] == 5 && vlog[6] == 5 && vlog[7] == 6 && vlog[8] == 7, "R6", vlog[6], 5);
    chk(done && !err, "R6", {done, err}, 2);
  endtask

  task automatic t_limit_ok();
    clr_model(); need[DEPTH-1] = MAXP;
    kick(); wait_done();
    chk(erases == MAXP, "R8", erases, MAXP);
    chk(done && !err, "R8", {done, err}, 2);
    chk(vcnt == DEPTH + MAXP - 1, "R8", vcnt, DEPTH + MAXP - 1);
  endtask

  task automatic t_limit_fail();
    clr_model(); need[DEPTH-1] = MAXP + 1;
    kick(); wait_done();
    repeat (5) @(negedge clk);
    chk(erases == MAXP, "R7", erases, MAXP);
    chk(done && err, "R7", {done, err}, 3);
    chk(last_wd == 8'h00, "R7", last_wd, 0);
    chk(vcnt == DEPTH + MAXP - 1, "R7", vcnt, DEPTH + MAXP - 1);
  endtask

  task automatic t_restart();
    clr_model();
    kick();
    chk(!done && !err, "R9", {done, err}, 0);
    wait_done();
    chk(done && !err && erases == 1, "R9", erases, 1);
    chk(vlog[0] == 0 && vcnt == DEPTH, "R9", vlog[0], 0);
  endtask

  initial begin
    clr_model();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_clean();
    t_resume();
    t_limit_ok();
    t_limit_fail();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule